// File: doc/BRIEF.md
# Atomic-Store Signature Filter with Lock Hand-off

This block keeps a small per-core Bloom filter for shared-memory coherence. Inside a critical section, every store whose region carries an atomic effect hashes its word address into a 256-bit local signature. Ordinary stores leave the signature alone. When the core gives up a lock, the signature is pushed out as one vector that rides on the lock transfer message. The local copy is cleared in the same step, so the next critical section starts empty.

The core that takes the lock next imports the vector. It is ORed into a separate received signature. Loads inside the critical section query the received signature to decide whether their cached word might be stale and must be self-invalidated. A hit may be a false positive, but a word that was inserted always hits. Leaving the critical section clears the received signature.

Each data path is a valid/ready stream. The insert and import streams never apply back-pressure, so their ready outputs are tied high. The export stream holds its vector and its valid flag until the consumer takes it. Release requests, critical-section exit and the query port are plain control and status pins.

Top module: `atomic_sig_filter`

## Requirements
- R1: After reset, exp_valid is 0 and qry_hit is 0 for every address.
- R2: The hash indices are formed from w_k = ins_addr >> (2+4k), taken as 32 bits, for k = 0 and 1. Index k is the XOR of the four bytes of w_k. An accepted insert with ins_atomic=1 sets both index bits in the local signature. Bit n of exp_vec is signature bit n.
- R3: An insert beat with ins_atomic=0, or a cycle with ins_valid=0, leaves the local signature unchanged.
- R4: If rel_req is 1 while no export is pending, then in the next cycle exp_valid is 1. exp_vec then equals the local signature, including any atomic insert made in the same cycle as the request, and the local signature restarts empty.
- R5: While exp_valid=1 and exp_ready=0, exp_valid stays 1 and exp_vec does not change. After a cycle with both signals at 1, exp_valid is 0. Atomic inserts made while an export is pending go into the new local signature.
- R6: rel_req is ignored while an export is pending.
- R7: ins_ready and imp_ready are always 1. An imp_valid beat ORs imp_vec into the received signature.
- R8: qry_hit is 1 in the same cycle exactly when both hash bits of qry_addr (hashed as in R2) are set in the received signature. An address whose bits were imported never misses.
- R9: cs_exit clears the received signature. If an import arrives in the same cycle, the received signature becomes exactly imp_vec.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Store beat valid |
| ins_ready | output | 1 | Insert ready, always 1 |
| ins_addr | input | 32 | Store byte address |
| ins_atomic | input | 1 | Store region has an atomic effect |
| qry_addr | input | 32 | Load byte address to test |
| qry_hit | output | 1 | Address may have been written by the previous lock holder |
| rel_req | input | 1 | Lock release: export the signature |
| exp_valid | output | 1 | Exported vector valid |
| exp_ready | input | 1 | Consumer takes the exported vector |
| exp_vec | output | 256 | Exported signature |
| imp_valid | input | 1 | Received vector valid |
| imp_ready | output | 1 | Import ready, always 1 |
| imp_vec | input | 256 | Signature arriving with a lock |
| cs_exit | input | 1 | Critical section ends |

## Verification
The bench sweeps thousands of query addresses against an arithmetic model of the received signature. A wrong hash slice or a missing AND between the two bits would show up as a false miss or a wrong hit pattern. It fires an insert and a release in the same cycle, where a design that ordered the export first would drop the new address from the vector. It stalls the export consumer while issuing a second release and further inserts. A design that accepted the second release would lose those inserts or change exp_vec under back-pressure. It also exits the critical section in the same cycle as an import, where a design with the wrong priority would either keep stale bits or drop the fresh vector.

// File: rtl/sigf_pkg.sv
package sigf_pkg;
  typedef enum logic {EXP_IDLE = 1'b0, EXP_HOLD = 1'b1} exp_state_e;
endpackage

// File: rtl/sigf_hash.sv
module sigf_hash #(
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 8,
  parameter int NUM_HASH = 2,
  parameter int WORD_OFS = 2,
  parameter int STEP     = 4,
  parameter int SIG_BITS = 1 << IDX_W
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [SIG_BITS-1:0] mask
);
  localparam int CHUNKS = (ADDR_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W  = CHUNKS * IDX_W;

  logic [NUM_HASH*IDX_W-1:0] idx_flat;

  for (genvar k = 0; k < NUM_HASH; k++) begin : g_fold
    logic [PAD_W-1:0] w;
    logic [IDX_W-1:0] hv;
    always_comb begin
      w  = PAD_W'(addr) >> (WORD_OFS + STEP * k);
      hv = '0;
      for (int c = 0; c < CHUNKS; c++) hv = hv ^ w[c*IDX_W +: IDX_W];
    end
    assign idx_flat[k*IDX_W +: IDX_W] = hv;
  end

  always_comb begin
    mask = '0;
    for (int k = 0; k < NUM_HASH; k++) mask[idx_flat[k*IDX_W +: IDX_W]] = 1'b1;
  end
endmodule

// File: rtl/sigf_local.sv
module sigf_local
  import sigf_pkg::*;
#(
  parameter int SIG_BITS = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ins_fire,
  input  logic [SIG_BITS-1:0] ins_mask,
  input  logic                rel_req,
  input  logic                exp_ready,
  output logic                exp_valid,
  output logic [SIG_BITS-1:0] exp_vec
);
  exp_state_e          st_q;
  logic [SIG_BITS-1:0] loc_q;
  logic [SIG_BITS-1:0] merged;
  logic                start;

  assign exp_valid = (st_q == EXP_HOLD);
  assign start     = rel_req && !exp_valid;
  assign merged    = loc_q | (ins_fire ? ins_mask : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= EXP_IDLE;
      loc_q   <= '0;
      exp_vec <= '0;
    end else if (start) begin
      st_q    <= EXP_HOLD;
      exp_vec <= merged;
      loc_q   <= '0;
    end else begin
      loc_q <= merged;
      if (exp_valid && exp_ready) st_q <= EXP_IDLE;
    end
  end

  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_valid && !exp_ready) |=> (exp_valid && $stable(exp_vec)));
  a_r4_insert_first: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ins_fire) |=> ((exp_vec & $past(ins_mask)) == $past(ins_mask)));
  a_r3_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!ins_fire && !start) |=> (loc_q == $past(loc_q)));
  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_valid && !exp_ready && rel_req) |=> $stable(exp_vec));
endmodule

// File: rtl/sigf_recv.sv
module sigf_recv #(
  parameter int SIG_BITS = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                imp_fire,
  input  logic [SIG_BITS-1:0] imp_vec,
  input  logic                cs_exit,
  input  logic [SIG_BITS-1:0] q_mask,
  output logic                hit
);
  logic [SIG_BITS-1:0] recv_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        recv_q <= '0;
    else if (cs_exit)  recv_q <= imp_fire ? imp_vec : '0;
    else if (imp_fire) recv_q <= recv_q | imp_vec;
  end

  assign hit = ((recv_q & q_mask) == q_mask);

  a_r9_exit_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_exit && !imp_fire) |=> !hit);
  a_r7_import_kept: assert property (@(posedge clk) disable iff (!rst_n)
    imp_fire |=> ((recv_q & $past(imp_vec)) == $past(imp_vec)));
  a_r7_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_exit |=> ((recv_q & $past(recv_q)) == $past(recv_q)));
endmodule

// File: rtl/atomic_sig_filter.sv
module atomic_sig_filter #(
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 8,
  parameter int NUM_HASH = 2,
  parameter int WORD_OFS = 2,
  parameter int STEP     = 4,
  localparam int SIG_BITS = 1 << IDX_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ins_valid,
  output logic                ins_ready,
  input  logic [ADDR_W-1:0]   ins_addr,
  input  logic                ins_atomic,
  input  logic [ADDR_W-1:0]   qry_addr,
  output logic                qry_hit,
  input  logic                rel_req,
  output logic                exp_valid,
  input  logic                exp_ready,
  output logic [SIG_BITS-1:0] exp_vec,
  input  logic                imp_valid,
  output logic                imp_ready,
  input  logic [SIG_BITS-1:0] imp_vec,
  input  logic                cs_exit
);
  logic [SIG_BITS-1:0] ins_mask, qry_mask;
  logic                ins_fire;

  assign ins_ready = 1'b1;
  assign imp_ready = 1'b1;
  assign ins_fire  = ins_valid && ins_ready && ins_atomic;

  sigf_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .NUM_HASH(NUM_HASH),
              .WORD_OFS(WORD_OFS), .STEP(STEP), .SIG_BITS(SIG_BITS))
    u_hash_ins (.addr(ins_addr), .mask(ins_mask));

  sigf_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .NUM_HASH(NUM_HASH),
              .WORD_OFS(WORD_OFS), .STEP(STEP), .SIG_BITS(SIG_BITS))
    u_hash_qry (.addr(qry_addr), .mask(qry_mask));

  sigf_local #(.SIG_BITS(SIG_BITS)) u_local (
    .clk(clk), .rst_n(rst_n), .ins_fire(ins_fire), .ins_mask(ins_mask),
    .rel_req(rel_req), .exp_ready(exp_ready), .exp_valid(exp_valid),
    .exp_vec(exp_vec));

  sigf_recv #(.SIG_BITS(SIG_BITS)) u_recv (
    .clk(clk), .rst_n(rst_n), .imp_fire(imp_valid && imp_ready),
    .imp_vec(imp_vec), .cs_exit(cs_exit), .q_mask(qry_mask), .hit(qry_hit));

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> !exp_valid);
  a_r7_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_ready && imp_ready));
endmodule

// File: tb/sim_atomic_sig_filter.sv
module sim_atomic_sig_filter;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic ins_valid = 0, ins_atomic = 0, rel_req = 0, exp_ready = 1;
  logic imp_valid = 0, cs_exit = 0;
  logic [31:0] ins_addr = 0, qry_addr = 0;
  logic [255:0] imp_vec = 0;
  logic ins_ready, imp_ready, qry_hit, exp_valid;
  logic [255:0] exp_vec;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  atomic_sig_filter u0 (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_addr(ins_addr), .ins_atomic(ins_atomic), .qry_addr(qry_addr),
    .qry_hit(qry_hit), .rel_req(rel_req), .exp_valid(exp_valid),
    .exp_ready(exp_ready), .exp_vec(exp_vec), .imp_valid(imp_valid),
    .imp_ready(imp_ready), .imp_vec(imp_vec), .cs_exit(cs_exit));

  function automatic logic [7:0] hidx(input logic [31:0] a, input int k);
    logic [31:0] w;
    w = a >> (2 + 4 * k);
    return w[7:0] ^ w[15:8] ^ w[23:16] ^ w[31:24];
  endfunction

  function automatic logic [255:0] hmask(input logic [31:0] a);
    logic [255:0] m;
    m = '0;
    m[hidx(a, 0)] = 1'b1;
    m[hidx(a, 1)] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] gen_addr(input int i);
    return 32'(i) * 32'h0001_3579 + 32'h0400_0010;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_hit(input logic [31:0] a, input logic [255:0] model, input string req);
    bit e;
    qry_addr = a; #1;
    e = model[hidx(a, 0)] && model[hidx(a, 1)];
    chk(qry_hit == e, req, 256'(qry_hit), 256'(e));
  endtask

  task automatic do_insert(input logic [31:0] a, input logic atomic);
    ins_valid = 1; ins_addr = a; ins_atomic = atomic;
    tick();
    ins_valid = 0; ins_atomic = 0;
  endtask

  task automatic do_release(input logic [255:0] expv, input string req);
    rel_req = 1; tick(); rel_req = 0;
    chk(exp_valid == 1'b1, req, 256'(exp_valid), 256'(1));
    chk(exp_vec == expv, req, exp_vec, expv);
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [255:0] model, recv, v2;
    logic [31:0] b, c;
    tick(); tick(); tick();
    rst_n = 1;
    // R1 reset state
    chk(exp_valid == 1'b0, "R1", 256'(exp_valid), 256'(0));
    for (int i = 0; i < 64; i++) chk_hit(gen_addr(i * 7), '0, "R1");
    // R7 ready levels
    chk(ins_ready && imp_ready, "R7", 256'({ins_ready, imp_ready}), 256'(3));

    // R2/R3 inserts: atomic interleaved with non-atomic
    model = '0;
    for (int i = 0; i < 24; i++) begin
      do_insert(gen_addr(i), 1'b1);
      model |= hmask(gen_addr(i));
      do_insert(gen_addr(i + 500), 1'b0);
      ins_addr = gen_addr(i + 900); tick();
    end
    do_release(model, "R2_R3_R4");
    // R4 local cleared after export
    do_release('0, "R4");

    // R5/R6 back-pressure
    model = hmask(gen_addr(3)) | hmask(gen_addr(4));
    do_insert(gen_addr(3), 1'b1);
    do_insert(gen_addr(4), 1'b1);
    exp_ready = 0;
    rel_req = 1; tick(); rel_req = 0;
    chk(exp_vec == model, "R4", exp_vec, model);
    b = 32'hDEAD_BEE0;
    for (int i = 0; i < 3; i++) begin
      rel_req = 1;
      if (i == 1) begin ins_valid = 1; ins_atomic = 1; ins_addr = b; end
      tick();
      ins_valid = 0; ins_atomic = 0;
      chk(exp_valid == 1'b1, "R5", 256'(exp_valid), 256'(1));
      chk(exp_vec == model, "R5_R6", exp_vec, model);
    end
    rel_req = 0;
    exp_ready = 1; tick();
    chk(exp_valid == 1'b0, "R5", 256'(exp_valid), 256'(0));
    do_release(hmask(b), "R5_R6");

    // R4 same-cycle insert and release
    c = 32'h1234_5678;
    ins_valid = 1; ins_atomic = 1; ins_addr = c; rel_req = 1;
    tick();
    ins_valid = 0; ins_atomic = 0; rel_req = 0;
    chk(exp_vec == hmask(c), "R4", exp_vec, hmask(c));
    tick();
    do_release('0, "R4");

    // R7/R8 import and query sweep
    recv = '0;
    for (int i = 0; i < 8; i++) recv |= hmask(gen_addr(i * 31));
    imp_vec = recv; imp_valid = 1; tick(); imp_valid = 0;
    for (int i = 0; i < 8; i++) chk_hit(gen_addr(i * 31), recv, "R8");
    for (int i = 0; i < 4096; i++) chk_hit(32'(i) * 32'h0001_0004 + 32'(i % 4), recv, "R8");
    v2 = hmask(32'hCAFE_0000) | hmask(32'h0BAD_F00C);
    imp_vec = v2; imp_valid = 1; tick(); imp_valid = 0;
    recv |= v2;
    chk_hit(32'hCAFE_0000, recv, "R7");
    chk_hit(gen_addr(0), recv, "R7");
    for (int i = 0; i < 512; i++) chk_hit(gen_addr(i), recv, "R7_R8");

    // R9 exit clears
    cs_exit = 1; tick(); cs_exit = 0;
    for (int i = 0; i < 256; i++) chk_hit(gen_addr(i * 31), '0, "R9");
    imp_vec = recv; imp_valid = 1; tick(); imp_valid = 0;
    imp_vec = v2; imp_valid = 1; cs_exit = 1; tick(); imp_valid = 0; cs_exit = 0;
    for (int i = 0; i < 512; i++) chk_hit(gen_addr(i), v2, "R9");
    chk_hit(32'hCAFE_0000, v2, "R9");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule